// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input pulse stream by a ratio set from channel-select digits. One clock domain runs at the rate of the pulses being divided. A prescaler counts input cycles and ends each of its cycles after either 41 or 40 input cycles. A swallow counter decides which of the two lengths is used. A main counter counts prescaler cycles and, when it finishes, emits the block's output pulse. That same pulse reloads both counters, so each division period runs into the next one without a gap.

With swallow value A and main value Np, the first A prescaler cycles of a period are long (41 input cycles) and the remaining Np−A cycles are short (40 input cycles). The period is therefore 40·Np + A input cycles. A small combinational front end turns the selected channel into the two values. Three BCD digits give the whole-MHz figure. A hundreds-of-kHz digit and a quarter-step code give the sub-MHz offset in 25 kHz units. The output pulse would drive a phase comparator; for example, 334 MHz plus 350 kHz yields a ratio of 13,374.

Top module: `pswd_divider`

## Requirements
- R1: In steady operation, two consecutive rising edges of `div_out` are exactly 40·Np + A input clock cycles apart. Np and A are the values loaded at the first of those two pulses.
- R2: When A is 0, every prescaler cycle in the period is 40 input cycles long, so the period is 40·Np.
- R3: `div_out` is high for exactly one clock cycle per period.
- R4: The main value is Np = 100·`sel_mhz_h` + 10·`sel_mhz_t` + `sel_mhz_u`. Each digit is a 4-bit binary-coded decimal value.
- R5: The swallow value is A = 4·`sel_khz_h` + `sel_khz_q`. `sel_khz_h` is the hundreds-of-kHz digit (0..9). `sel_khz_q` counts 25 kHz steps within that 100 kHz (0..3). For example, 350 kHz gives 14, and 975 kHz gives the largest value, 39.
- R6: A change on the select inputs does not alter the period already in progress. The new values are taken only at the next output pulse.
- R7: A main value of 0 is treated as 1.
- R8: A swallow value that is not below the main value is reduced to Np−1.
- R9: While `rst` is high, `div_out` is low and both counters hold the decoded values. The first output pulse comes 40·Np + A cycles after the last clock edge at which `rst` was high.
- R10: The prescaler modulus changes only at a prescaler terminal count. The prescaler count never exceeds 40, and reaches 40 only while the long modulus is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the rate of the pulses being divided |
| rst | input | 1 | Synchronous reset, active high |
| sel_mhz_h | input | 4 | Hundreds-of-MHz BCD digit |
| sel_mhz_t | input | 4 | Tens-of-MHz BCD digit |
| sel_mhz_u | input | 4 | Units-of-MHz BCD digit |
| sel_khz_h | input | 4 | Hundreds-of-kHz BCD digit |
| sel_khz_q | input | 2 | Number of 25 kHz steps within the 100 kHz digit |
| div_out | output | 1 | One-cycle pulse at the end of each division period |

## Verification
Three events fall on the same clock edge: the reload of both counters at the end of a period, the prescaler's terminal count, and the choice of modulus for the first prescaler cycle of the new period. If the new swallow value is zero and the old one was not, or the reverse, the first prescaler cycle must already use the new modulus. The bench provokes this by stepping between configurations with A=0, A=39, a clamped A and the one-cycle main count, with each new value applied just after a reload pulse. It then judges every period by its exact length in input cycles. A one-cycle shift in the modulus decision, or a reload that takes the old value, changes that length by at least one.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

   // Width of one binary-coded decimal select digit
   localparam int unsigned DIGIT_W = 4;

   // Width of the quarter-step code inside a 100 kHz digit
   localparam int unsigned QSTEP_W = 2;

   // Output stage variants
   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_style_e;

   typedef logic [DIGIT_W-1:0] digit_t;
   typedef logic [QSTEP_W-1:0] qstep_t;

endpackage

// File: rtl/pswd_chan_decode.sv
module pswd_chan_decode
   import pswd_pkg::*;
#(
   parameter int unsigned NP_W = 10,
   parameter int unsigned A_W  = 6
) (
   input  digit_t          mhz_h,
   input  digit_t          mhz_t,
   input  digit_t          mhz_u,
   input  digit_t          khz_h,
   input  qstep_t          khz_q,
   output logic [NP_W-1:0] np_val,
   output logic [A_W-1:0]  a_val
);

   localparam int unsigned STEPS_PER_DIGIT = 1 << QSTEP_W;

   logic [NP_W-1:0] np_raw;
   logic [NP_W-1:0] np_fix;
   logic [A_W-1:0]  a_raw;

   always_comb begin
      np_raw = NP_W'(100) * NP_W'(mhz_h)
             + NP_W'(10)  * NP_W'(mhz_t)
             + NP_W'(mhz_u);
      np_fix = (np_raw == '0) ? NP_W'(1) : np_raw;
      a_raw  = A_W'(STEPS_PER_DIGIT) * A_W'(khz_h) + A_W'(khz_q);
      if (NP_W'(a_raw) >= np_fix) begin
         a_val = A_W'(np_fix - NP_W'(1));
      end else begin
         a_val = a_raw;
      end
      np_val = np_fix;
   end

endmodule

// File: rtl/pswd_prescaler.sv
module pswd_prescaler #(
   parameter int unsigned LO_MOD = 40,
   localparam int unsigned PC_W  = $clog2(LO_MOD + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            mod_hi,
   output logic [PC_W-1:0] pre_cnt,
   output logic            pre_tc
);

   logic [PC_W-1:0] last_val;

   always_comb begin
      last_val = mod_hi ? PC_W'(LO_MOD) : PC_W'(LO_MOD - 1);
      pre_tc   = (pre_cnt == last_val);
   end

   always_ff @(posedge clk) begin
      if (rst || pre_tc) begin
         pre_cnt <= '0;
      end else begin
         pre_cnt <= pre_cnt + PC_W'(1);
      end
   end

endmodule

// File: rtl/pswd_counters.sv
module pswd_counters #(
   parameter int unsigned NP_W = 10,
   parameter int unsigned A_W  = 6
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            step,
   input  logic [NP_W-1:0] np_load,
   input  logic [A_W-1:0]  a_load,
   output logic [NP_W-1:0] n_left,
   output logic [A_W-1:0]  a_left,
   output logic            mod_hi,
   output logic            period_end
);

   always_comb begin
      mod_hi     = (a_left != '0);
      period_end = step && (n_left == NP_W'(1));
   end

   always_ff @(posedge clk) begin
      if (rst || period_end) begin
         n_left <= np_load;
         a_left <= a_load;
      end else if (step) begin
         n_left <= n_left - NP_W'(1);
         if (a_left != '0) begin
            a_left <= a_left - A_W'(1);
         end
      end
   end

endmodule

// File: rtl/pswd_divider.sv
module pswd_divider
   import pswd_pkg::*;
#(
   parameter int unsigned LO_MOD    = 40,
   parameter int unsigned NP_W      = 10,
   parameter int unsigned A_W       = 6,
   parameter out_style_e  OUT_STYLE = OUT_REG,
   localparam int unsigned PC_W     = $clog2(LO_MOD + 1)
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [3:0] sel_mhz_h,
   input  logic [3:0] sel_mhz_t,
   input  logic [3:0] sel_mhz_u,
   input  logic [3:0] sel_khz_h,
   input  logic [1:0] sel_khz_q,
   output logic       div_out
);

   // Elaboration-time parameter checks
   if (LO_MOD < 2) begin : g_bad_mod
      $error("pswd_divider: LO_MOD must be at least 2");
   end
   if (NP_W < 10) begin : g_bad_np
      $error("pswd_divider: NP_W must hold three BCD digits (>= 10)");
   end
   if (A_W > NP_W) begin : g_bad_aw
      $error("pswd_divider: A_W must not exceed NP_W");
   end
   if ((1 << A_W) < (4 * 10)) begin : g_bad_a
      $error("pswd_divider: A_W too narrow for the swallow range");
   end

   logic [NP_W-1:0] np_val;
   logic [A_W-1:0]  a_val;
   logic [PC_W-1:0] pre_cnt;
   logic            pre_tc;
   logic            mod_hi;
   logic [NP_W-1:0] n_left;
   logic [A_W-1:0]  a_left;
   logic            period_end;

   pswd_chan_decode #(
      .NP_W (NP_W),
      .A_W  (A_W)
   ) u_decode (
      .mhz_h  (sel_mhz_h),
      .mhz_t  (sel_mhz_t),
      .mhz_u  (sel_mhz_u),
      .khz_h  (sel_khz_h),
      .khz_q  (sel_khz_q),
      .np_val (np_val),
      .a_val  (a_val)
   );

   pswd_prescaler #(
      .LO_MOD (LO_MOD)
   ) u_pre (
      .clk     (clk),
      .rst     (rst),
      .mod_hi  (mod_hi),
      .pre_cnt (pre_cnt),
      .pre_tc  (pre_tc)
   );

   pswd_counters #(
      .NP_W (NP_W),
      .A_W  (A_W)
   ) u_cnt (
      .clk        (clk),
      .rst        (rst),
      .step       (pre_tc),
      .np_load    (np_val),
      .a_load     (a_val),
      .n_left     (n_left),
      .a_left     (a_left),
      .mod_hi     (mod_hi),
      .period_end (period_end)
   );

   if (OUT_STYLE == OUT_REG) begin : g_out_reg
      logic pulse_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            pulse_q <= 1'b0;
         end else begin
            pulse_q <= period_end;
         end
      end
      assign div_out = pulse_q;
   end else begin : g_out_comb
      assign div_out = period_end && !rst;
   end

endmodule

// File: rtl/pswd_divider_chk.sv
module pswd_divider_chk #(
   parameter int unsigned LO_MOD = 40,
   parameter int unsigned NP_W   = 10,
   parameter int unsigned A_W    = 6,
   localparam int unsigned PC_W  = $clog2(LO_MOD + 1)
) (
   input logic            clk,
   input logic            rst,
   input logic            div_out,
   input logic [PC_W-1:0] pre_cnt,
   input logic            pre_tc,
   input logic            mod_hi,
   input logic [A_W-1:0]  a_left,
   input logic [NP_W-1:0] n_left
);

   // R3
   pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
      div_out |=> !div_out);

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> !div_out);

   // R10
   prescaler_bound_chk: assert property (@(posedge clk) disable iff (rst)
      (pre_cnt <= PC_W'(LO_MOD)) && ((pre_cnt != PC_W'(LO_MOD)) || mod_hi));

   // R10
   modulus_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !pre_tc |=> $stable(mod_hi));

   // R6
   count_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !pre_tc |=> ($stable(n_left) && $stable(a_left)));

   // R7
   main_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      n_left != '0);

   // R8
   swallow_below_main_chk: assert property (@(posedge clk) disable iff (rst)
      (a_left == '0) || (NP_W'(a_left) < n_left));

endmodule

bind pswd_divider pswd_divider_chk #(
   .LO_MOD (LO_MOD),
   .NP_W   (NP_W),
   .A_W    (A_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .div_out (div_out),
   .pre_cnt (pre_cnt),
   .pre_tc  (pre_tc),
   .mod_hi  (mod_hi),
   .a_left  (a_left),
   .n_left  (n_left)
);

// File: tb/pswd_divider_test.sv
module pswd_divider_test;

   logic       clk = 1'b0;
   logic       rst;
   logic [3:0] mh, mt, mu, kh;
   logic [1:0] kq;
   logic       div_out;

   always #5 clk = ~clk;

   pswd_divider uut (
      .clk       (clk),
      .rst       (rst),
      .sel_mhz_h (mh),
      .sel_mhz_t (mt),
      .sel_mhz_u (mu),
      .sel_khz_h (kh),
      .sel_khz_q (kq),
      .div_out   (div_out)
   );

   typedef struct {
      int unsigned cyc;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          checks = 0;
   int          fails  = 0;
   bit          done   = 1'b0;
   int unsigned prev;

   // Expected period from the requirements: R4, R5, R7, R8, R1
   function automatic int unsigned ref_period(int h, int t, int u, int k, int q);
      int np, a;
      np = 100 * h + 10 * t + u;
      if (np == 0) np = 1;
      a = 4 * k + q;
      if (a >= np) a = np - 1;
      return 40 * np + a;
   endfunction

   task automatic drive(int h, int t, int u, int k, int q);
      mh = 4'(h); mt = 4'(t); mu = 4'(u); kh = 4'(k); kq = 2'(q);
   endtask

   task automatic wait_pulse();
      do @(negedge clk); while (div_out !== 1'b1);
   endtask

   task automatic push(int unsigned c, string tag);
      sb.push_back('{c, tag});
   endtask

   // Change the select inputs just after a pulse; hold for n periods
   task automatic apply(int h, int t, int u, int k, int q, int n, string tag,
                        bit at_pulse);
      if (!at_pulse) wait_pulse();
      drive(h, t, u, k, q);
      push(prev, "R6");
      for (int i = 1; i < n; i++) begin
         wait_pulse();
         push(ref_period(h, t, u, k, q), tag);
      end
      prev = ref_period(h, t, u, k, q);
   endtask

   // Change the select inputs in the middle of a period
   task automatic apply_mid(int h, int t, int u, int k, int q, string tag);
      wait_pulse();
      push(prev, "R6");
      repeat (20) @(negedge clk);
      drive(h, t, u, k, q);
      wait_pulse();
      push(ref_period(h, t, u, k, q), tag);
      prev = ref_period(h, t, u, k, q);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   // Monitor: measures each period and pops its expectation
   int unsigned mon_cnt  = 0;
   bit          mon_run  = 1'b0;
   bit          mon_last = 1'b0;

   initial begin
      wait (rst === 1'b0);
      forever begin
         @(negedge clk);
         if (div_out === 1'b1) begin
            checks++;
            if (mon_last) begin
               fails++;
               $display("FAIL R3: pulse wider than one cycle, actual=2+ expected=1");
            end
            if (mon_run) begin
               checks++;
               if (sb.size() == 0) begin
                  fails++;
                  $display("FAIL R1: unexpected pulse, actual=%0d expected=none",
                           mon_cnt + 1);
               end else begin
                  exp_t e;
                  e = sb.pop_front();
                  if (mon_cnt + 1 != e.cyc) begin
                     fails++;
                     $display("FAIL %s: period actual=%0d expected=%0d",
                              e.tag, mon_cnt + 1, e.cyc);
                  end
               end
            end
            mon_run = 1'b1;
            mon_cnt = 0;
         end else begin
            mon_cnt++;
         end
         mon_last = (div_out === 1'b1);
      end
   end

   // Driver
   initial begin
      int unsigned first;
      rst = 1'b1;
      drive(0, 0, 5, 0, 0);
      repeat (4) begin
         @(negedge clk);
         checks++;
         if (div_out !== 1'b0) begin
            fails++;
            $display("FAIL R9: output during reset actual=%b expected=0", div_out);
         end
      end
      rst  = 1'b0;
      prev = ref_period(0, 0, 5, 0, 0);
      // R9: first pulse after release
      first = 0;
      do begin
         @(negedge clk);
         first++;
      end while (div_out !== 1'b1 && first < 1000);
      checks++;
      if (first != prev) begin
         fails++;
         $display("FAIL R9: first period actual=%0d expected=%0d", first, prev);
      end
      // R1 R4 R5: 334 MHz + 350 kHz gives 13374
      apply(3, 3, 4, 3, 2, 2, "R1", 1'b1);
      // R2: swallow value 0
      apply(0, 1, 2, 0, 0, 3, "R2", 1'b0);
      // R1 R5: largest legal swallow value 39 with Np=50
      apply(0, 5, 0, 9, 3, 3, "R5", 1'b0);
      // R8: A=5 against Np=3 clamps to 2
      apply(0, 0, 3, 1, 1, 3, "R8", 1'b0);
      // R7: Np=0 runs as 1, A clamps to 0
      apply(0, 0, 0, 0, 3, 3, "R7", 1'b0);
      // R6: mid-period change
      apply_mid(0, 1, 2, 0, 2, "R6");
      apply(0, 0, 7, 1, 2, 2, "R4", 1'b0);
      wait_pulse();
      @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R1: pending periods actual=%0d expected=0", sb.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1: watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule